// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Termination Controller

This block is the sequencing and stop logic of a four-channel DMA engine that owns one shared bus. Each channel carries a source pointer, a destination pointer, a unit counter, a transfer width, two pointer-stepping modes, an enable, an end flag and an interrupt enable. Every unit is a dual-address move: one read from the source, then one write of the same data to the destination. Three global controls stop every channel at once: a master enable input, an NMI flag and an address-error flag.

The controller decides when each channel stops. A channel ends normally when its counter reaches zero. Software can stop one channel by clearing its enable bit. An NMI event, an address error or a cleared master enable stops all channels. Every stop is applied only between units. A unit that has started always finishes its write, and its pointers and counter are updated. After each unit the bus request is dropped.

The control path is one FSM with five states. IDLE arbitrates. It moves to REQ when the run condition holds and an eligible channel has aligned pointers. If the winner's pointers are misaligned it stays in IDLE and raises the address error. REQ raises the bus request. It returns to IDLE if the run condition or the chosen channel's eligibility is lost, and moves to RD on grant. RD issues the read and moves to WR on acknowledge. WR issues the write and moves to UPD on acknowledge. UPD steps the chosen channel's registers and returns to IDLE, which releases the bus.

Top module: `dmat_ctrl`

## Requirements
- R1: A channel is eligible when its enable is 1, its end flag is 0 and its count is nonzero. Each unit decrements the count by one. When the count reaches zero the end flag goes to 1 and the channel starts no further unit.
- R2: `end_irq[i]` is 1 exactly when `end_flag[i]` and the channel's interrupt enable are both 1.
- R3: Clearing a channel's enable through `en_clr` stops that channel after the unit in progress. The remaining count is kept and the end flag stays 0.
- R4: A pulse on `nmi_evt` sets `nmi_flag`. While `nmi_flag` is 1 no channel starts a unit, and no end flag is set by the stop.
- R5: A stop raised while a read is pending still lets that unit's write complete. The source pointer, destination pointer and count are then updated for that unit.
- R6: The pointers step by the width after each unit. Width code 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. Mode code 1 increments, 2 decrements, and 0 or 3 holds. The source and destination modes are chosen separately.
- R7: When several channels are eligible, the lowest-numbered one wins. Arbitration happens only between units.
- R8: After any stop, `bus_req` goes to 0 and stays 0 while the stop condition lasts.
- R9: Clearing `nmi_flag` (through `nmi_clr`) resumes any channel that is still enabled and has units left, and it then runs to its end.
- R10: A start is refused if the winning channel's source or destination pointer is misaligned: odd for 2-byte width, not a multiple of 4 for 4-byte width. The refusal sets `aerr_flag`, makes no bus request and leaves the count unchanged. `aerr_flag` stops all channels until `aerr_clr` is pulsed.
- R11: Driving `master_en` to 0 stops all channels after the current unit without setting an end flag. Raising it again resumes the channels that are still enabled.
- R12: If a stop appears while the request is still waiting for `bus_gnt`, the request is withdrawn. No read or write is performed and the count is unchanged.
- R13: A configuration write (`cfg_we` with `cfg_ch`) loads the channel's pointers, count, width, modes and interrupt enable, and clears its end flag. It does not change the channel's enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel selected for configuration |
| cfg_sar | input | 32 | Source pointer to load |
| cfg_dar | input | 32 | Destination pointer to load |
| cfg_cnt | input | 16 | Unit count to load |
| cfg_size | input | 2 | Width code |
| cfg_src_mode | input | 2 | Source stepping mode |
| cfg_dst_mode | input | 2 | Destination stepping mode |
| cfg_ie | input | 1 | Interrupt enable to load |
| en_set | input | 4 | Per-channel enable set pulses |
| en_clr | input | 4 | Per-channel enable clear pulses (win over set) |
| master_en | input | 1 | Global run enable level |
| nmi_evt | input | 1 | NMI event pulse, sets the NMI flag |
| nmi_clr | input | 1 | Clears the NMI flag |
| aerr_clr | input | 1 | Clears the address-error flag |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | 32 | Access address |
| bus_size | output | 2 | Access width code |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ack | input | 1 | Access complete |
| end_flag | output | 4 | Per-channel end flags |
| end_irq | output | 4 | Per-channel end interrupt requests |
| chan_en | output | 4 | Per-channel enable bits |
| nmi_flag | output | 1 | NMI flag |
| aerr_flag | output | 1 | Address-error flag |
| obs_ch | input | 2 | Channel selected for observation |
| obs_sar | output | 32 | Source pointer of the observed channel |
| obs_dar | output | 32 | Destination pointer of the observed channel |
| obs_cnt | output | 16 | Count of the observed channel |

## Verification
The bench raises each kind of stop while a read is outstanding. A design that cuts the unit short would lose the matching write from the scoreboard or leave the count and pointers one unit behind. After each software or global stop it checks that the end flag and interrupt stay low. An implementation that marks every stop as an end would raise them. Misaligned pointers and a stop raised while the grant is still missing are both checked for the absence of any bus access, which exposes a controller that checks too late or keeps a stale request. Two channels enabled in the same cycle must produce their writes in index order, and a resumed channel must finish exactly the units it had left.

// File: rtl/dmat_pkg.sv
package dmat_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_RD,
        S_WR,
        S_UPD
    } dmat_state_e;

    localparam logic [1:0] STEP_INC = 2'b01;
    localparam logic [1:0] STEP_DEC = 2'b10;

    // byte count of one unit for a width code
    function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // misalignment of a pointer for a width code (low two address bits)
    function automatic logic misaligned(input logic [1:0] sz, input logic [1:0] lo);
        unique case (sz)
            2'd0:    return 1'b0;
            2'd1:    return lo[0];
            default: return |lo;
        endcase
    endfunction

endpackage

// File: rtl/dmat_arb.sv
module dmat_arb #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] gnt,
    output logic           any,
    output logic [CHW-1:0] idx
);

    logic [NCH:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_pri
            assign gnt[i]    = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate

    assign any = seen[NCH];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (gnt[i]) idx = CHW'(i);
        end
    end

endmodule

// File: rtl/dmat_glob.sv
module dmat_glob (
    input  logic clk,
    input  logic rst_n,
    input  logic dme,
    input  logic nmi_set,
    input  logic nmi_clr,
    input  logic ae_set,
    input  logic ae_clr,
    output logic nmif,
    output logic ae,
    output logic run_ok
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmif <= 1'b0;
            ae   <= 1'b0;
        end else begin
            if (nmi_set)      nmif <= 1'b1;
            else if (nmi_clr) nmif <= 1'b0;
            if (ae_set)       ae   <= 1'b1;
            else if (ae_clr)  ae   <= 1'b0;
        end
    end

    assign run_ok = dme & ~nmif & ~ae;

endmodule

// File: rtl/dmat_chan.sv
module dmat_chan
    import dmat_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_sar,
    input  logic [AW-1:0] cfg_dar,
    input  logic [CW-1:0] cfg_cnt,
    input  logic [1:0]    cfg_sz,
    input  logic [1:0]    cfg_smd,
    input  logic [1:0]    cfg_dmd,
    input  logic          cfg_ie,
    input  logic          de_set,
    input  logic          de_clr,
    input  logic          upd,
    output logic [AW-1:0] sar,
    output logic [AW-1:0] dar,
    output logic [CW-1:0] cnt,
    output logic [1:0]    sz,
    output logic          ie,
    output logic          de,
    output logic          te,
    output logic          ready
);

    logic [1:0]    smd_q, dmd_q;
    logic [AW-1:0] step, sar_nx, dar_nx;

    assign step = AW'(unit_bytes(sz));

    always_comb begin
        unique case (smd_q)
            STEP_INC: sar_nx = sar + step;
            STEP_DEC: sar_nx = sar - step;
            default:  sar_nx = sar;
        endcase
        unique case (dmd_q)
            STEP_INC: dar_nx = dar + step;
            STEP_DEC: dar_nx = dar - step;
            default:  dar_nx = dar;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar   <= '0;
            dar   <= '0;
            cnt   <= '0;
            sz    <= '0;
            smd_q <= '0;
            dmd_q <= '0;
            ie    <= 1'b0;
            de    <= 1'b0;
            te    <= 1'b0;
        end else begin
            if (cfg_we) begin
                sar   <= cfg_sar;
                dar   <= cfg_dar;
                cnt   <= cfg_cnt;
                sz    <= cfg_sz;
                smd_q <= cfg_smd;
                dmd_q <= cfg_dmd;
                ie    <= cfg_ie;
                te    <= 1'b0;
            end else if (upd) begin
                sar <= sar_nx;
                dar <= dar_nx;
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) te <= 1'b1;
            end
            if (de_clr)      de <= 1'b0;
            else if (de_set) de <= 1'b1;
        end
    end

    assign ready = de & ~te & (cnt != '0);

    // R1: the end flag only rises together with an exhausted count
    p_te_at_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(te) |-> (cnt == '0));

endmodule

// File: rtl/dmat_ctrl.sv
module dmat_ctrl
    import dmat_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [$clog2(NCH)-1:0] cfg_ch,
    input  logic [AW-1:0]          cfg_sar,
    input  logic [AW-1:0]          cfg_dar,
    input  logic [CW-1:0]          cfg_cnt,
    input  logic [1:0]             cfg_size,
    input  logic [1:0]             cfg_src_mode,
    input  logic [1:0]             cfg_dst_mode,
    input  logic                   cfg_ie,
    input  logic [NCH-1:0]         en_set,
    input  logic [NCH-1:0]         en_clr,
    input  logic                   master_en,
    input  logic                   nmi_evt,
    input  logic                   nmi_clr,
    input  logic                   aerr_clr,
    output logic                   bus_req,
    input  logic                   bus_gnt,
    output logic                   bus_rd,
    output logic                   bus_wr,
    output logic [AW-1:0]          bus_addr,
    output logic [1:0]             bus_size,
    output logic [DW-1:0]          bus_wdata,
    input  logic [DW-1:0]          bus_rdata,
    input  logic                   bus_ack,
    output logic [NCH-1:0]         end_flag,
    output logic [NCH-1:0]         end_irq,
    output logic [NCH-1:0]         chan_en,
    output logic                   nmi_flag,
    output logic                   aerr_flag,
    input  logic [$clog2(NCH)-1:0] obs_ch,
    output logic [AW-1:0]          obs_sar,
    output logic [AW-1:0]          obs_dar,
    output logic [CW-1:0]          obs_cnt
);

    localparam int CHW = $clog2(NCH);

    dmat_state_e    state, state_nx;
    logic [CHW-1:0] cur;
    logic [DW-1:0]  data_q;

    logic [AW-1:0]  sar_a [NCH];
    logic [AW-1:0]  dar_a [NCH];
    logic [CW-1:0]  cnt_a [NCH];
    logic [1:0]     sz_a  [NCH];
    logic [NCH-1:0] ie_v, ready, win_vec, upd_v;
    logic [CHW-1:0] win_idx;
    logic           win_any, run_ok, mis_w, go, ae_set, upd;

    // per-channel register sets
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            dmat_chan #(.AW(AW), .CW(CW)) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .cfg_we  (cfg_we && (cfg_ch == CHW'(i))),
                .cfg_sar (cfg_sar),
                .cfg_dar (cfg_dar),
                .cfg_cnt (cfg_cnt),
                .cfg_sz  (cfg_size),
                .cfg_smd (cfg_src_mode),
                .cfg_dmd (cfg_dst_mode),
                .cfg_ie  (cfg_ie),
                .de_set  (en_set[i]),
                .de_clr  (en_clr[i]),
                .upd     (upd_v[i]),
                .sar     (sar_a[i]),
                .dar     (dar_a[i]),
                .cnt     (cnt_a[i]),
                .sz      (sz_a[i]),
                .ie      (ie_v[i]),
                .de      (chan_en[i]),
                .te      (end_flag[i]),
                .ready   (ready[i])
            );
            assign upd_v[i] = upd && (cur == CHW'(i));
        end
    endgenerate

    dmat_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
        .req (ready),
        .gnt (win_vec),
        .any (win_any),
        .idx (win_idx)
    );

    dmat_glob u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .dme     (master_en),
        .nmi_set (nmi_evt),
        .nmi_clr (nmi_clr),
        .ae_set  (ae_set),
        .ae_clr  (aerr_clr),
        .nmif    (nmi_flag),
        .ae      (aerr_flag),
        .run_ok  (run_ok)
    );

    assign mis_w = misaligned(sz_a[win_idx], sar_a[win_idx][1:0]) |
                   misaligned(sz_a[win_idx], dar_a[win_idx][1:0]);
    assign go    = run_ok & win_any & ~mis_w;

    // state register and per-unit capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cur    <= '0;
            data_q <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && go)      cur    <= win_idx;
            if (state == S_RD && bus_ack)   data_q <= bus_rdata;
        end
    end

    // next-state logic: stops are looked at only in IDLE and REQ
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (go) state_nx = S_REQ;
            S_REQ: begin
                if (!run_ok || !ready[cur]) state_nx = S_IDLE;
                else if (bus_gnt)           state_nx = S_RD;
            end
            S_RD:   if (bus_ack) state_nx = S_WR;
            S_WR:   if (bus_ack) state_nx = S_UPD;
            S_UPD:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req = 1'b0;
        bus_rd  = 1'b0;
        bus_wr  = 1'b0;
        upd     = 1'b0;
        ae_set  = 1'b0;
        unique case (state)
            S_IDLE: ae_set  = run_ok & win_any & mis_w;
            S_REQ:  bus_req = 1'b1;
            S_RD: begin
                bus_req = 1'b1;
                bus_rd  = 1'b1;
            end
            S_WR: begin
                bus_req = 1'b1;
                bus_wr  = 1'b1;
            end
            S_UPD: begin
                bus_req = 1'b1;
                upd     = 1'b1;
            end
            default: ;
        endcase
    end

    assign bus_addr  = (state == S_WR) ? dar_a[cur] : sar_a[cur];
    assign bus_size  = sz_a[cur];
    assign bus_wdata = data_q;
    assign end_irq   = end_flag & ie_v;

    assign obs_sar = sar_a[obs_ch];
    assign obs_dar = dar_a[obs_ch];
    assign obs_cnt = cnt_a[obs_ch];

    logic [NCH-1:0] low_mask;
    assign low_mask = (NCH'(1) << cur) - NCH'(1);

    // R5: a read in flight is never abandoned
    p_read_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ack) |=> bus_rd);

    // R5: every write is the second half of an acknowledged read
    p_write_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr) |-> $past(bus_rd && bus_ack));

    // R4: a request only opens while the global run condition holds
    p_start_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(run_ok));

    // R7: the channel taking the bus had no lower-numbered eligible rival
    p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> (($past(ready) & low_mask) == '0));

    // R12: no access without the grant
    p_access_granted_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> bus_gnt);

    // R10: the address-error flag rises only from an idle arbitration
    p_ae_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aerr_flag) |-> $past(state == S_IDLE));

endmodule

// File: tb/tb_dmat_ctrl.sv
module tb_dmat_ctrl;

    localparam int NCH = 4;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int CW  = 16;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
    } item_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_ch = '0;
    logic [AW-1:0]  cfg_sar = '0, cfg_dar = '0;
    logic [CW-1:0]  cfg_cnt = '0;
    logic [1:0]     cfg_size = '0, cfg_src_mode = '0, cfg_dst_mode = '0;
    logic           cfg_ie = 1'b0;
    logic [NCH-1:0] en_set = '0, en_clr = '0;
    logic           master_en = 1'b0, nmi_evt = 1'b0, nmi_clr = 1'b0, aerr_clr = 1'b0;
    logic           bus_req, bus_rd, bus_wr;
    logic           bus_gnt = 1'b0, bus_ack = 1'b0;
    logic [AW-1:0]  bus_addr;
    logic [1:0]     bus_size;
    logic [DW-1:0]  bus_wdata;
    logic [DW-1:0]  bus_rdata = '0;
    logic [NCH-1:0] end_flag, end_irq, chan_en;
    logic           nmi_flag, aerr_flag;
    logic [1:0]     obs_ch = '0;
    logic [AW-1:0]  obs_sar, obs_dar;
    logic [CW-1:0]  obs_cnt;

    logic gnt_en = 1'b1;
    int   ntot = 0, nbad = 0;
    int   mon_tot = 0, mon_bad = 0, rd_count = 0;
    item_t sb[$];

    always #2.5 clk = ~clk;

    dmat_ctrl #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sar(cfg_sar), .cfg_dar(cfg_dar),
        .cfg_cnt(cfg_cnt), .cfg_size(cfg_size), .cfg_src_mode(cfg_src_mode),
        .cfg_dst_mode(cfg_dst_mode), .cfg_ie(cfg_ie),
        .en_set(en_set), .en_clr(en_clr), .master_en(master_en),
        .nmi_evt(nmi_evt), .nmi_clr(nmi_clr), .aerr_clr(aerr_clr),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .end_flag(end_flag), .end_irq(end_irq), .chan_en(chan_en),
        .nmi_flag(nmi_flag), .aerr_flag(aerr_flag),
        .obs_ch(obs_ch), .obs_sar(obs_sar), .obs_dar(obs_dar), .obs_cnt(obs_cnt)
    );

    function automatic logic [31:0] mkdata(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[15:0]};
    endfunction

    // bus model and scoreboard monitor: pops one expected item per write
    always @(negedge clk) begin
        item_t e;
        if (!rst_n) begin
            bus_ack = 1'b0;
            bus_gnt = 1'b0;
        end else begin
            bus_gnt = bus_req & gnt_en;
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_rd) begin
                bus_rdata = mkdata(bus_addr);
                bus_ack   = 1'b1;
                rd_count++;
            end else if (bus_wr) begin
                bus_ack = 1'b1;
                mon_tot++;
                if (sb.size() == 0) begin
                    mon_bad++;
                    $display("FAIL R5 unexpected write act=%h/%h exp=none", bus_addr, bus_wdata);
                end else begin
                    e = sb.pop_front();
                    if (bus_addr !== e.a || bus_wdata !== e.d) begin
                        mon_bad++;
                        $display("FAIL R6 write act=%h/%h exp=%h/%h", bus_addr, bus_wdata, e.a, e.d);
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        ntot++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic push_unit(input logic [31:0] s, input logic [31:0] d);
        item_t it;
        it.a = d;
        it.d = mkdata(s);
        sb.push_back(it);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int ch, input logic [31:0] s, input logic [31:0] d,
                       input int n, input logic [1:0] sz, input logic [1:0] sm,
                       input logic [1:0] dm, input logic ie);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sar = s; cfg_dar = d;
        cfg_cnt = CW'(n); cfg_size = sz; cfg_src_mode = sm; cfg_dst_mode = dm; cfg_ie = ie;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_en(input logic [3:0] m);
        @(negedge clk); en_set = m;
        @(negedge clk); en_set = '0;
    endtask

    task automatic clr_en(input logic [3:0] m);
        en_clr = m;
        @(negedge clk); en_clr = '0;
    endtask

    task automatic wait_te(input int ch);
        int k = 0;
        while (!end_flag[ch] && k < 3000) begin @(negedge clk); k++; end
        if (!end_flag[ch]) check("R1 end flag timeout", 0, 1);
    endtask

    task automatic wait_rd_cnt(input int n);
        int k = 0;
        @(negedge clk);
        while (!(bus_rd && obs_cnt == CW'(n)) && k < 3000) begin @(negedge clk); k++; end
        if (k >= 3000) check("R5 read wait timeout", 0, 1);
    endtask

    task automatic run_tests;
        int rd0;
        // reset state
        check("R1 reset end_flag", 64'(end_flag), 0);
        check("R2 reset irq", 64'(end_irq), 0);
        check("R4 reset nmi_flag", 64'(nmi_flag), 0);
        check("R10 reset aerr_flag", 64'(aerr_flag), 0);
        check("R8 reset bus_req", 64'(bus_req), 0);

        // R1 R2 R6: 3 longword units, both pointers incrementing
        cfg(1, 32'h100, 32'h200, 3, 2'd2, 2'd1, 2'd1, 1'b1);
        push_unit(32'h100, 32'h200); push_unit(32'h104, 32'h204); push_unit(32'h108, 32'h208);
        obs_ch = 2'd1;
        set_en(4'b0010);
        wait_te(1);
        settle(4);
        check("R1 count exhausted", 64'(obs_cnt), 0);
        check("R6 sar inc long", 64'(obs_sar), 64'h10C);
        check("R6 dar inc long", 64'(obs_dar), 64'h20C);
        check("R2 irq with ie", 64'(end_irq[1]), 1);
        check("R8 bus idle after end", 64'(bus_req), 0);
        check("R5 scoreboard drained", 64'(sb.size()), 0);

        // R6 R2: word, source decrement, destination hold, ie off
        clr_en(4'hF);
        cfg(2, 32'h300, 32'h400, 2, 2'd1, 2'd2, 2'd0, 1'b0);
        push_unit(32'h300, 32'h400); push_unit(32'h2FE, 32'h400);
        obs_ch = 2'd2;
        set_en(4'b0100);
        wait_te(2);
        settle(4);
        check("R6 sar dec word", 64'(obs_sar), 64'h2FC);
        check("R6 dar hold", 64'(obs_dar), 64'h400);
        check("R2 no irq without ie", 64'(end_irq[2]), 0);

        // R7: channels 0 and 3 enabled together, byte width
        clr_en(4'hF);
        cfg(3, 32'h500, 32'h600, 1, 2'd0, 2'd1, 2'd1, 1'b0);
        cfg(0, 32'h700, 32'h800, 2, 2'd0, 2'd1, 2'd3, 1'b0);
        push_unit(32'h700, 32'h800); push_unit(32'h701, 32'h800); push_unit(32'h500, 32'h600);
        set_en(4'b1001);
        wait_te(3);
        settle(4);
        check("R7 order by index", 64'(sb.size()), 0);
        check("R7 both ended", 64'(end_flag & 4'b1001), 64'h9);

        // R3: enable cleared while third unit reads
        clr_en(4'hF);
        cfg(0, 32'h900, 32'hA00, 5, 2'd2, 2'd1, 2'd1, 1'b1);
        push_unit(32'h900, 32'hA00); push_unit(32'h904, 32'hA04); push_unit(32'h908, 32'hA08);
        obs_ch = 2'd0;
        set_en(4'b0001);
        wait_rd_cnt(3);
        clr_en(4'b0001);
        settle(40);
        check("R3 count kept", 64'(obs_cnt), 2);
        check("R3 no end flag", 64'(end_flag[0]), 0);
        check("R5 sar updated", 64'(obs_sar), 64'h90C);
        check("R3 no extra unit", 64'(sb.size()), 0);
        check("R8 bus released", 64'(bus_req), 0);

        // R13 R4 R5 R8: NMI during first read of a 4-unit run
        clr_en(4'hF);
        cfg(1, 32'h1000, 32'h2000, 4, 2'd2, 2'd1, 2'd1, 1'b1);
        obs_ch = 2'd1;
        check("R13 load clears end flag", 64'(end_flag[1]), 0);
        push_unit(32'h1000, 32'h2000);
        set_en(4'b0010);
        wait_rd_cnt(4);
        nmi_evt = 1'b1; @(negedge clk); nmi_evt = 1'b0;
        settle(40);
        check("R4 nmi flag", 64'(nmi_flag), 1);
        check("R5 count after nmi", 64'(obs_cnt), 3);
        check("R5 sar after nmi", 64'(obs_sar), 64'h1004);
        check("R5 dar after nmi", 64'(obs_dar), 64'h2004);
        check("R4 no end flag", 64'(end_flag[1]), 0);
        check("R2 no irq on abort", 64'(end_irq[1]), 0);
        check("R8 bus released nmi", 64'(bus_req), 0);
        check("R4 no more units", 64'(sb.size()), 0);

        // R9: resume
        push_unit(32'h1004, 32'h2004); push_unit(32'h1008, 32'h2008); push_unit(32'h100C, 32'h200C);
        nmi_clr = 1'b1; @(negedge clk); nmi_clr = 1'b0;
        wait_te(1);
        settle(4);
        check("R9 resumed to end", 64'(obs_cnt), 0);
        check("R9 remaining units done", 64'(sb.size()), 0);
        check("R9 nmi flag clear", 64'(nmi_flag), 0);

        // R10: odd source for word width
        clr_en(4'hF);
        cfg(2, 32'h301, 32'h400, 2, 2'd1, 2'd1, 2'd1, 1'b0);
        obs_ch = 2'd2;
        rd0 = rd_count;
        set_en(4'b0100);
        settle(20);
        check("R10 aerr word", 64'(aerr_flag), 1);
        check("R10 count unchanged", 64'(obs_cnt), 2);
        check("R10 no read", 64'(rd_count - rd0), 0);
        check("R10 no end flag", 64'(end_flag[2]), 0);
        clr_en(4'b0100);
        aerr_clr = 1'b1; @(negedge clk); aerr_clr = 1'b0;
        settle(2);
        check("R10 aerr cleared", 64'(aerr_flag), 0);

        // R10: destination not 4-aligned for long width
        cfg(3, 32'h100, 32'h202, 1, 2'd2, 2'd1, 2'd1, 1'b0);
        rd0 = rd_count;
        set_en(4'b1000);
        settle(20);
        check("R10 aerr long dst", 64'(aerr_flag), 1);
        check("R10 no read long", 64'(rd_count - rd0), 0);
        clr_en(4'b1000);
        aerr_clr = 1'b1; @(negedge clk); aerr_clr = 1'b0;

        // R11: master enable dropped during first read
        cfg(0, 32'hB00, 32'hC00, 4, 2'd2, 2'd1, 2'd1, 1'b0);
        obs_ch = 2'd0;
        push_unit(32'hB00, 32'hC00);
        set_en(4'b0001);
        wait_rd_cnt(4);
        master_en = 1'b0;
        settle(40);
        check("R11 count after dme", 64'(obs_cnt), 3);
        check("R11 no end flag", 64'(end_flag[0]), 0);
        check("R11 no more units", 64'(sb.size()), 0);
        check("R8 bus released dme", 64'(bus_req), 0);
        push_unit(32'hB04, 32'hC04); push_unit(32'hB08, 32'hC08); push_unit(32'hB0C, 32'hC0C);
        master_en = 1'b1;
        wait_te(0);
        settle(4);
        check("R11 resume completes", 64'(obs_cnt), 0);
        check("R11 resumed units", 64'(sb.size()), 0);

        // R12: stop while waiting for grant
        clr_en(4'hF);
        gnt_en = 1'b0;
        cfg(3, 32'hD00, 32'hE00, 2, 2'd2, 2'd1, 2'd1, 1'b0);
        obs_ch = 2'd3;
        rd0 = rd_count;
        set_en(4'b1000);
        settle(10);
        check("R12 request pending", 64'(bus_req), 1);
        clr_en(4'b1000);
        settle(5);
        check("R12 request withdrawn", 64'(bus_req), 0);
        check("R12 no read", 64'(rd_count - rd0), 0);
        check("R12 count unchanged", 64'(obs_cnt), 2);
        gnt_en = 1'b1;
        settle(10);
        check("R12 stays idle", 64'(bus_req), 0);
    endtask

    initial begin
        logic wd;
        wd = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        master_en = 1'b1;
        @(negedge clk);
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            ntot++;
            nbad++;
            $display("FAIL watchdog act=timeout exp=done");
        end
        $display("test done: total=%0d bad=%0d", ntot + mon_tot, nbad + mon_bad);
        $finish;
    end

endmodule